// File: doc/BRIEF.md
# Watchdog Prescaler Timer

A free-running binary counter that advances once per main-clock cycle. It serves three roles. Four of its upper stages can be read by the core as a coarse time base. Once enabled, it acts as a watchdog that requests a core reset when software fails to clear it in time. After reset it also acts as the oscillator settling delay, holding the core in reset until the counter first reaches its top value.

Software picks one of two read formats through a write-only mode register. In the narrow format only the most significant status bit is returned and the others read zero. In the wide format all four status bits are returned. The counter is cleared by a timer-clear strobe, which the instruction decoder issues, and by a pulse marking release from the low-power hold state. The `rst_req_o` output holds the core in reset during the settling delay. Afterwards it carries single-cycle watchdog reset pulses.

Top module: `wdog_prescaler`

## Requirements
- R1: After `rst_ni` is released, `rst_req_o` stays high for 2^(CNT_W-1) clock cycles (65536 with the default 17-bit counter). It then falls, and the counter restarts from zero in the same cycle.
- R2: During that settling delay, `tmr_clr_i` and `hold_rel_i` are ignored, and the counter keeps counting.
- R3: Outside a clear, the counter increments by one per clock. The status bits TM3..TM0 are counter bits CNT_W-2 down to CNT_W-5 (bits 15..12 by default, toggling every 2^15..2^12 cycles).
- R4: When mode bit 2 is 1, `rd_data_o` returns TM3..TM0, with TM3 in bit 3.
- R5: When mode bit 2 is 0, `rd_data_o` returns TM3 in bit 3 and zero in bits 2..0. Mode bits 3, 1 and 0 have no effect on the read data.
- R6: The mode register resets to 0. A write through `mode_we_i` takes effect on the read data from the cycle after the write edge.
- R7: After the settling delay, a `tmr_clr_i` strobe clears the whole counter to zero at the next edge.
- R8: After the settling delay, a `hold_rel_i` pulse clears the whole counter to zero at the next edge.
- R9: With `wdt_en_i` high, consider an edge at which the counter holds 2^(CNT_W-1)-1 and no clear is present. At that edge `rst_req_o` rises for exactly one cycle and the counter returns to zero, so the pulse comes 2^(CNT_W-1) cycles after the last clear.
- R10: When a clear and a watchdog overflow fall on the same edge, the clear wins: the counter goes to zero and no pulse is issued.
- R11: With `wdt_en_i` low, no reset pulse is issued, and the counter counts through 2^(CNT_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tmr_clr_i | input | 1 | Timer-clear strobe from the instruction decoder |
| hold_rel_i | input | 1 | Pulse on release from the hold state |
| mode_we_i | input | 1 | Mode register write enable |
| mode_wdata_i | input | MODE_W (4) | Mode register write data; bit 2 selects the wide read format |
| rd_data_o | output | TM_W (4) | Status read bus |
| wdt_en_i | input | 1 | Watchdog enable |
| rst_req_o | output | 1 | Core reset request: a level during settling, a one-cycle pulse on watchdog overflow |

## Verification
The properties assume that `rst_ni` is held low across at least one rising edge, so that every `$past` term samples reset values. They also assume that the clear inputs, the enable and the mode write are synchronous to `clk_i`. Within that, the properties accept clears of any length and in any cycle. The stimulus changes inputs only just after a rising edge. It keeps each clear to a single cycle so the counter position stays known, and it places one clear exactly on an overflow edge to exercise the collision. The stimulus uses a 14-bit counter so that every settling and watchdog window completes within a short run.

// File: rtl/wdog_prescaler_pkg.sv
`timescale 1ns/1ps
package wdog_prescaler_pkg;
  typedef enum logic {
    PH_WAIT = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/wdog_pre_cnt.sv
`timescale 1ns/1ps
module wdog_pre_cnt #(
  parameter int CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_top_o
);
  localparam logic [CNT_W-1:0] TOP = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_top_o = (cnt_q == TOP);
endmodule

// File: rtl/wdog_pre_seq.sv
`timescale 1ns/1ps
module wdog_pre_seq
  import wdog_prescaler_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_req_i,
  input  logic wdt_en_i,
  input  logic at_top_i,
  output logic run_o,
  output logic cnt_clr_o,
  output logic rst_req_o
);
  phase_e ph_q, ph_d;
  logic   req_q, req_d;
  logic   ovf;

  always_comb begin
    ph_d      = ph_q;
    req_d     = 1'b0;
    ovf       = 1'b0;
    cnt_clr_o = 1'b0;
    case (ph_q)
      PH_WAIT: begin
        // settling delay: software clears have no say here
        cnt_clr_o = at_top_i;
        req_d     = ~at_top_i;
        if (at_top_i) ph_d = PH_RUN;
      end
      PH_RUN: begin
        ovf       = wdt_en_i & at_top_i & ~clr_req_i;
        cnt_clr_o = clr_req_i | ovf;
        req_d     = ovf;
      end
      default: begin
        ph_d  = PH_WAIT;
        req_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_WAIT;
      req_q <= 1'b1;
    end else begin
      ph_q  <= ph_d;
      req_q <= req_d;
    end
  end

  assign run_o     = (ph_q == PH_RUN);
  assign rst_req_o = req_q;
endmodule

// File: rtl/wdog_pre_rd.sv
`timescale 1ns/1ps
module wdog_pre_rd #(
  parameter int TM_W       = 4,
  parameter int MODE_W     = 4,
  parameter int RD_ALL_BIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MODE_W-1:0] wdata_i,
  input  logic [TM_W-1:0]   tm_i,
  output logic [TM_W-1:0]   rd_o
);
  logic [MODE_W-1:0] mode_q;
  logic              unused_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= '0;
    else if (we_i) mode_q <= wdata_i;
  end

  // only the read-format bit is consumed here
  assign unused_mode = ^mode_q;

  for (genvar i = 0; i < TM_W; i++) begin : g_rd
    if (i == TM_W-1) begin : g_top
      assign rd_o[i] = tm_i[i];
    end else begin : g_low
      assign rd_o[i] = tm_i[i] & mode_q[RD_ALL_BIT];
    end
  end
endmodule

// File: rtl/wdog_prescaler.sv
`timescale 1ns/1ps
module wdog_prescaler #(
  parameter int CNT_W      = 17,
  parameter int TM_W       = 4,
  parameter int MODE_W     = 4,
  parameter int RD_ALL_BIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmr_clr_i,
  input  logic              hold_rel_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  output logic [TM_W-1:0]   rd_data_o,
  input  logic              wdt_en_i,
  output logic              rst_req_o
);
  localparam int TM_MSB = CNT_W - 2;
  localparam int TM_LSB = TM_MSB - TM_W + 1;

  logic [CNT_W-1:0] cnt_w;
  logic             at_top_w;
  logic             cnt_clr_w;
  logic             clr_req_w;
  logic             run_w;

  assign clr_req_w = tmr_clr_i | hold_rel_i;

  wdog_pre_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cnt_clr_w),
    .cnt_o    (cnt_w),
    .at_top_o (at_top_w)
  );

  wdog_pre_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_req_i (clr_req_w),
    .wdt_en_i  (wdt_en_i),
    .at_top_i  (at_top_w),
    .run_o     (run_w),
    .cnt_clr_o (cnt_clr_w),
    .rst_req_o (rst_req_o)
  );

  wdog_pre_rd #(
    .TM_W       (TM_W),
    .MODE_W     (MODE_W),
    .RD_ALL_BIT (RD_ALL_BIT)
  ) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mode_we_i),
    .wdata_i (mode_wdata_i),
    .tm_i    (cnt_w[TM_MSB:TM_LSB]),
    .rd_o    (rd_data_o)
  );
endmodule

// File: rtl/wdog_prescaler_chk.sv
`timescale 1ns/1ps
module wdog_prescaler_chk #(
  parameter int CNT_W = 17,
  parameter int TM_W  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_req_i,
  input logic             wdt_en_i,
  input logic             run_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [TM_W-1:0]  rd_data_o,
  input logic             rst_req_o
);
  localparam logic [CNT_W-1:0] TOP = {1'b0, {(CNT_W-1){1'b1}}};
  localparam int TM_MSB = CNT_W - 2;

  // R1
  wait_holds_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> rst_req_o);

  // R2
  wait_ignores_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && clr_req_i && cnt_i != TOP) |=> cnt_i == $past(cnt_i) + 1'b1);

  // R3
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_req_i && !(wdt_en_i && cnt_i == TOP)) |=> cnt_i == $past(cnt_i) + 1'b1);

  // R3
  top_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[TM_W-1] == cnt_i[TM_MSB]);

  // R9
  ovf_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && wdt_en_i && !clr_req_i && cnt_i == TOP) |=> (rst_req_o && cnt_i == '0));

  // R9
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && rst_req_o) |=> !rst_req_o);

  // R10
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && clr_req_i) |=> (!rst_req_o && cnt_i == '0));

  // R11
  wdt_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wdt_en_i) |=> !rst_req_o);
endmodule

bind wdog_prescaler wdog_prescaler_chk #(
  .CNT_W (CNT_W),
  .TM_W  (TM_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_req_i (clr_req_w),
  .wdt_en_i  (wdt_en_i),
  .run_i     (run_w),
  .cnt_i     (cnt_w),
  .rd_data_o (rd_data_o),
  .rst_req_o (rst_req_o)
);

// File: tb/wdog_prescaler_tb_top.sv
`timescale 1ns/1ps
module wdog_prescaler_tb_top;
  // short counter: settling and watchdog windows are 2^13 cycles
  localparam int CW = 14;
  localparam int T  = 1 << (CW-1);

  typedef struct {
    string    tag;
    logic [3:0] rd;
    logic     rst;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr_clr = 1'b0, hold_rel = 1'b0, mode_we = 1'b0, wdt_en = 1'b0;
  logic [3:0] mode_wdata = '0;
  logic [3:0] rd_data;
  logic rst_req;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  exp_t exp_q[$];
  exp_t cur;

  always #2.5 clk = ~clk;

  wdog_prescaler #(.CNT_W(CW)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tmr_clr_i    (tmr_clr),
    .hold_rel_i   (hold_rel),
    .mode_we_i    (mode_we),
    .mode_wdata_i (mode_wdata),
    .rd_data_o    (rd_data),
    .wdt_en_i     (wdt_en),
    .rst_req_o    (rst_req)
  );

  // monitor: one expectation per cycle, compared at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      cur = exp_q.pop_front();
      n_cmp++;
      if (rd_data !== cur.rd || rst_req !== cur.rst) begin
        n_bad++;
        $display("FAIL %s: rd=%b rst_req=%b expected rd=%b rst_req=%b",
                 cur.tag, rd_data, rst_req, cur.rd, cur.rst);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_now(input string tag, input logic [3:0] rd, input logic rst);
    exp_t e;
    e.tag = tag; e.rd = rd; e.rst = rst;
    exp_q.push_back(e);
  endtask

  task automatic pulse_clr();
    tmr_clr = 1'b1; step(1); tmr_clr = 1'b0;
  endtask

  task automatic pulse_hold();
    hold_rel = 1'b1; step(1); hold_rel = 1'b0;
  endtask

  task automatic set_mode(input logic [3:0] v);
    mode_we = 1'b1; mode_wdata = v; step(1); mode_we = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    step(3);
    expect_now("R1 reset state", 4'b0000, 1'b1);
    step(1);
    rst_n = 1'b1;                       // counter 0
    step(100);                          // 100
    pulse_clr();                        // 101, ignored
    pulse_hold();                       // 102, ignored
    step(T-1-102);                      // T-1
    // R6: mode still 0, narrow format; R2: clears ignored
    expect_now("R2 R6 settling end", 4'b1000, 1'b1);
    step(1);                            // counter 0
    expect_now("R1 settling release", 4'b0000, 1'b0);

    set_mode(4'b0100);                  // 1
    pulse_clr();                        // 0
    step(512);
    expect_now("R3 R4 wide TM0", 4'b0001, 1'b0);
    set_mode(4'b1011);                  // 513
    expect_now("R5 R6 narrow masks low", 4'b0000, 1'b0);
    step(16'h1200 - 513);               // 0x1200
    expect_now("R5 narrow TM3", 4'b1000, 1'b0);
    set_mode(4'b0100);                  // 0x1201
    expect_now("R4 R6 wide TM3 TM0", 4'b1001, 1'b0);
    step(16'h2000 - 16'h1201);          // 0x2000, overflow edge without watchdog
    expect_now("R11 no pulse when disabled", 4'b0000, 1'b0);
    step(16'h0400);                     // 0x2400
    expect_now("R11 counts past top", 4'b0010, 1'b0);

    wdt_en = 1'b1;
    pulse_hold();                       // 0
    expect_now("R8 hold release clears", 4'b0000, 1'b0);
    step(T-1);
    expect_now("R9 no early pulse", 4'b1111, 1'b0);
    pulse_clr();                        // clear on overflow edge
    expect_now("R10 clear wins", 4'b0000, 1'b0);
    step(1);                            // 1
    expect_now("R10 no late pulse", 4'b0000, 1'b0);
    step(T-2);                          // T-1
    expect_now("R9 before overflow", 4'b1111, 1'b0);
    step(1);                            // 0
    expect_now("R9 overflow pulse", 4'b0000, 1'b1);
    step(1);                            // 1
    expect_now("R9 pulse one cycle", 4'b0000, 1'b0);
    step(511);                          // 512
    expect_now("R9 restart from zero", 4'b0001, 1'b0);
    pulse_clr();                        // 0
    expect_now("R7 clear strobe", 4'b0000, 1'b0);
    step(3);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      done = 1'b1;
      summary();
      $finish;
    end
  end
endmodule